// File: doc/BRIEF.md
# Token-Passing Daisy-Chain Readout Controller

Each readout chip on a hybrid carries one of these controllers. The chips form a chain that shares one serial data path and one token line. A chip configured as a slave stays passive until the token reaches it. It then puts the hit words it has buffered onto the serial path toward its neighbour and hands the token on. While it does not hold the token, it forwards whatever arrives from upstream.

One chip at the end of the chain is configured as the master. On a trigger accept it sends an event header, then its own hit words. It then releases the token into the chain. While the token travels, the master repeats the data the slaves append. When the token comes back, the master closes the event with a trailer. If the token does not come back within a programmable number of clocks, the master closes the event with an error trailer instead.

A direction select swaps the roles of the two neighbour sides, so the whole chain can run in reverse as a redundant path. A run enable models the control bit that stops the serializer clock. While it is low, nothing advances.

Top module: `tokchain_readout`

## Requirements
- R1: When a slave samples the token while idle and its hit buffer is not empty, it sends every buffered word back to back from the next clock on. Each word is one start bit of value 1 followed by the HIT_W word bits, most significant bit first.
- R2: A slave drives the downstream token line high for exactly one clock, in the clock after its last data bit. With an empty buffer, that clock is the one right after the token was sampled.
- R3: While a chip is idle, and while a master waits for the token to return, the downstream data output equals the upstream data input delayed by one clock.
- R4: In master mode, a sampled L1 accept causes the following output sequence, starting with the next clock: a start bit of 1, then a 4-bit event count sent MSB first (0 for the first event after reset, incremented for each accepted L1), then the master's own buffered words in R1 format, then a one-clock token pulse on the downstream token line.
- R5: When a waiting master samples the returning token on the upstream token line, the next 16 output bits are 0 whatever the upstream data is. After that the master returns to repeating.
- R6: With tmo_limit = L, suppose the master's token pulse is in clock w and the token is not sampled on the clocks w+1 through w+L+1. Then the 16 bits from clock w+L+2 onward are all 1 (error trailer).
- R7: rev_dir = 0 makes side a upstream and side b downstream; rev_dir = 1 swaps them. The outputs on the upstream side are held at 0.
- R8: While run_en is low, no state changes and all outputs hold their value. When run_en returns high, the sequence continues where it stopped.
- R9: L1 has no effect in slave mode. A token arriving at an idle master has no effect.
- R10: The hit buffer holds DEPTH words. A push while it is full is dropped.
- R11: During and right after reset all outputs are 0, the chip is idle, and the event count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock (40 or 80 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Serializer clock enable; low freezes the block |
| is_master | input | 1 | 1 = master (framer), 0 = slave |
| rev_dir | input | 1 | Chain direction select |
| l1_acc | input | 1 | Trigger accept, used in master mode |
| tmo_limit | input | TMO_W | Token return timeout limit |
| hit_push | input | 1 | Write strobe into the hit buffer |
| hit_word | input | HIT_W | Hit word to buffer |
| tok_in_a | input | 1 | Token input from side a |
| dat_in_a | input | 1 | Serial data input from side a |
| tok_in_b | input | 1 | Token input from side b |
| dat_in_b | input | 1 | Serial data input from side b |
| tok_out_a | output | 1 | Token output toward side a |
| dat_out_a | output | 1 | Serial data output toward side a |
| tok_out_b | output | 1 | Token output toward side b |
| dat_out_b | output | 1 | Serial data output toward side b |

## Verification
The bench builds the block with DEPTH = 4, HIT_W = 10 and TMO_W = 8. A four-word buffer lets six pushes reach the overflow case. The count that follows then shows whether the dropped words were really lost. A small timeout limit of 5 brings the error trailer into reach within a few dozen clocks. The 10-bit words give 11-bit frames whose bit positions the bench works out itself.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int EVC_W = 4;
    localparam int HDR_W = EVC_W + 1;
    localparam int TRL_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_SEND,
        ST_TOKGO,
        ST_WAIT,
        ST_TRL
    } rd_state_e;

    typedef struct packed {
        logic tok;
        logic dat;
    } link_t;

    function automatic logic [HDR_W-1:0] hdr_bits(input logic [EVC_W-1:0] cnt);
        return {1'b1, cnt};
    endfunction

endpackage

// File: rtl/rdc_hit_fifo.sv
module rdc_hit_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = en && push && (cnt_q != CW'(DEPTH));
    assign do_pop  = en && pop && (cnt_q != '0);
    assign empty   = (cnt_q == '0);
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= nxt(wp_q);
            if (do_pop)  rp_q <= nxt(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/rdc_dir_mux.sv
module rdc_dir_mux
    import rdc_pkg::*;
(
    input  logic  rev,
    input  link_t a_in,
    input  link_t b_in,
    input  link_t dn_out,
    output link_t up_in,
    output link_t a_out,
    output link_t b_out
);
    always_comb begin
        if (rev) begin
            up_in = b_in;
            a_out = dn_out;
            b_out = '0;
        end else begin
            up_in = a_in;
            a_out = '0;
            b_out = dn_out;
        end
    end
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
    import rdc_pkg::*;
#(
    parameter int HIT_W = 10,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             is_master,
    input  logic             l1,
    input  link_t            up,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic [HIT_W-1:0] head,
    input  logic             empty,
    output logic             pop,
    output link_t            dn,
    output logic             idle
);
    localparam int FRM_W = HIT_W + 1;
    localparam int SH_W  = (FRM_W > HDR_W) ? FRM_W : HDR_W;
    localparam int MAXB  = (TRL_W > SH_W) ? TRL_W : SH_W;
    localparam int CNT_W = $clog2(MAXB) + 1;

    rd_state_e        st_q;
    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] bcnt_q;
    logic [EVC_W-1:0] evc_q;
    logic [TMO_W-1:0] tmo_q;
    logic             err_q;
    logic             dout_q;
    logic             tout_q;
    logic             start_slave;
    logic             last_bit;

    assign start_slave = (st_q == ST_IDLE) && !is_master && up.tok;
    assign last_bit    = (bcnt_q == CNT_W'(1));
    assign pop = en && !empty &&
                 (start_slave || (((st_q == ST_HDR) || (st_q == ST_SEND)) && last_bit));

    assign dn.tok = tout_q;
    assign dn.dat = dout_q;
    assign idle   = (st_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            bcnt_q <= '0;
            evc_q  <= '0;
            tmo_q  <= '0;
            err_q  <= 1'b0;
            dout_q <= 1'b0;
            tout_q <= 1'b0;
        end else if (en) begin
            tout_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    dout_q <= up.dat;
                    if (is_master && l1) begin
                        sh_q   <= SH_W'(hdr_bits(evc_q)) << (SH_W - HDR_W);
                        bcnt_q <= CNT_W'(HDR_W);
                        evc_q  <= evc_q + 1'b1;
                        st_q   <= ST_HDR;
                    end else if (start_slave) begin
                        if (empty) begin
                            tout_q <= 1'b1;
                        end else begin
                            sh_q   <= SH_W'({1'b1, head}) << (SH_W - FRM_W);
                            bcnt_q <= CNT_W'(FRM_W);
                            st_q   <= ST_SEND;
                        end
                    end
                end
                ST_HDR, ST_SEND: begin
                    dout_q <= sh_q[SH_W-1];
                    sh_q   <= sh_q << 1;
                    bcnt_q <= bcnt_q - 1'b1;
                    if (last_bit) begin
                        if (!empty) begin
                            sh_q   <= SH_W'({1'b1, head}) << (SH_W - FRM_W);
                            bcnt_q <= CNT_W'(FRM_W);
                            st_q   <= ST_SEND;
                        end else begin
                            st_q <= ST_TOKGO;
                        end
                    end
                end
                ST_TOKGO: begin
                    tout_q <= 1'b1;
                    dout_q <= up.dat;
                    tmo_q  <= '0;
                    st_q   <= is_master ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: begin
                    dout_q <= up.dat;
                    if (up.tok) begin
                        err_q  <= 1'b0;
                        bcnt_q <= CNT_W'(TRL_W);
                        st_q   <= ST_TRL;
                    end else if (tmo_q == tmo_limit) begin
                        err_q  <= 1'b1;
                        bcnt_q <= CNT_W'(TRL_W);
                        st_q   <= ST_TRL;
                    end else begin
                        tmo_q <= tmo_q + 1'b1;
                    end
                end
                ST_TRL: begin
                    dout_q <= err_q;
                    bcnt_q <= bcnt_q - 1'b1;
                    if (last_bit) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tokchain_readout.sv
module tokchain_readout
    import rdc_pkg::*;
#(
    parameter int HIT_W = 10,
    parameter int DEPTH = 8,
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             is_master,
    input  logic             rev_dir,
    input  logic             l1_acc,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             hit_push,
    input  logic [HIT_W-1:0] hit_word,
    input  logic             tok_in_a,
    input  logic             dat_in_a,
    input  logic             tok_in_b,
    input  logic             dat_in_b,
    output logic             tok_out_a,
    output logic             dat_out_a,
    output logic             tok_out_b,
    output logic             dat_out_b
);
    link_t            a_in, b_in, up_in, dn_out, a_out, b_out;
    logic [HIT_W-1:0] head;
    logic             empty, pop, idle_w;

    assign a_in.tok = tok_in_a;
    assign a_in.dat = dat_in_a;
    assign b_in.tok = tok_in_b;
    assign b_in.dat = dat_in_b;

    rdc_hit_fifo #(.W(HIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .en(run_en),
        .push(hit_push), .din(hit_word),
        .pop(pop), .dout(head), .empty(empty)
    );

    rdc_seq #(.HIT_W(HIT_W), .TMO_W(TMO_W)) u_seq (
        .clk(clk), .rst(rst), .en(run_en),
        .is_master(is_master), .l1(l1_acc), .up(up_in),
        .tmo_limit(tmo_limit), .head(head), .empty(empty),
        .pop(pop), .dn(dn_out), .idle(idle_w)
    );

    rdc_dir_mux u_dir (
        .rev(rev_dir), .a_in(a_in), .b_in(b_in), .dn_out(dn_out),
        .up_in(up_in), .a_out(a_out), .b_out(b_out)
    );

    assign tok_out_a = a_out.tok;
    assign dat_out_a = a_out.dat;
    assign tok_out_b = b_out.tok;
    assign dat_out_b = b_out.dat;
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic is_master,
    input logic rev_dir,
    input logic l1_acc,
    input logic tok_in_a,
    input logic dat_in_a,
    input logic tok_in_b,
    input logic dat_in_b,
    input logic tok_out_a,
    input logic dat_out_a,
    input logic tok_out_b,
    input logic dat_out_b,
    input logic idle_w
);
    logic up_tok, dn_tok_any;
    assign up_tok     = rev_dir ? tok_in_b : tok_in_a;
    assign dn_tok_any = tok_out_a || tok_out_b;

    AST_TOK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (run_en && dn_tok_any && !up_tok) |=> !dn_tok_any); // R2

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run_en ##1 $stable(rev_dir)) |->
        $stable({dat_out_a, dat_out_b, tok_out_a, tok_out_b})); // R8

    AST_REPEAT_FWD: assert property (@(posedge clk) disable iff (rst)
        (run_en && idle_w && !rev_dir ##1 !rev_dir) |->
        (dat_out_b == $past(dat_in_a))); // R3

    AST_REPEAT_REV: assert property (@(posedge clk) disable iff (rst)
        (run_en && idle_w && rev_dir ##1 rev_dir) |->
        (dat_out_a == $past(dat_in_b))); // R3

    AST_SLAVE_L1_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run_en && idle_w && !is_master && !up_tok) |=> idle_w); // R9

    AST_MASTER_TOK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run_en && idle_w && is_master && !l1_acc) |=> idle_w); // R9
endmodule

bind tokchain_readout rdc_checker u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .is_master(is_master),
    .rev_dir(rev_dir), .l1_acc(l1_acc),
    .tok_in_a(tok_in_a), .dat_in_a(dat_in_a),
    .tok_in_b(tok_in_b), .dat_in_b(dat_in_b),
    .tok_out_a(tok_out_a), .dat_out_a(dat_out_a),
    .tok_out_b(tok_out_b), .dat_out_b(dat_out_b),
    .idle_w(idle_w)
);

// File: tb/test_tokchain_readout.sv
module test_tokchain_readout;
    localparam int CLK_PERIOD = 10;
    localparam int HIT_W = 10;
    localparam int DEPTH = 4;
    localparam int TMO_W = 8;
    localparam int FRM_W = HIT_W + 1;
    localparam int WD_CYCLES = 20000;

    // table: [32] rev, [31:30] word count, [29:20] w0, [19:10] w1, [9:0] w2
    localparam int NV = 6;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 2'd0, 10'h000, 10'h000, 10'h000},
        {1'b0, 2'd1, 10'h2A5, 10'h000, 10'h000},
        {1'b0, 2'd2, 10'h3FF, 10'h000, 10'h000},
        {1'b0, 2'd3, 10'h155, 10'h001, 10'h200},
        {1'b1, 2'd1, 10'h0F3, 10'h000, 10'h000},
        {1'b1, 2'd0, 10'h000, 10'h000, 10'h000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b1, is_master = 1'b0, rev_dir = 1'b0, l1_acc = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd40;
    logic hit_push = 1'b0;
    logic [HIT_W-1:0] hit_word = '0;
    logic tok_in_a = 1'b0, dat_in_a = 1'b0, tok_in_b = 1'b0, dat_in_b = 1'b0;
    logic tok_out_a, dat_out_a, tok_out_b, dat_out_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tokchain_readout #(.HIT_W(HIT_W), .DEPTH(DEPTH), .TMO_W(TMO_W)) i_tokchain_readout (
        .clk(clk), .rst(rst), .run_en(run_en), .is_master(is_master),
        .rev_dir(rev_dir), .l1_acc(l1_acc), .tmo_limit(tmo_limit),
        .hit_push(hit_push), .hit_word(hit_word),
        .tok_in_a(tok_in_a), .dat_in_a(dat_in_a),
        .tok_in_b(tok_in_b), .dat_in_b(dat_in_b),
        .tok_out_a(tok_out_a), .dat_out_a(dat_out_a),
        .tok_out_b(tok_out_b), .dat_out_b(dat_out_b)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic logic dn_dat();
        return rev_dir ? dat_out_a : dat_out_b;
    endfunction
    function automatic logic dn_tok();
        return rev_dir ? tok_out_a : tok_out_b;
    endfunction
    function automatic logic up_side_any();
        return rev_dir ? (tok_out_b | dat_out_b) : (tok_out_a | dat_out_a);
    endfunction
    function automatic logic [HIT_W-1:0] vword(input logic [32:0] v, input int i);
        return v[29 - 10*i -: 10];
    endfunction
    function automatic logic frame_bit(input logic [HIT_W-1:0] w, input int b);
        return (b == 0) ? 1'b1 : w[HIT_W - b];
    endfunction

    task automatic set_up_tok(input logic t);
        if (rev_dir) tok_in_b = t; else tok_in_a = t;
    endtask

    task automatic push_word(input logic [HIT_W-1:0] w);
        hit_push = 1'b1;
        hit_word = w;
        @(negedge clk);
        hit_push = 1'b0;
    endtask

    task automatic token_pulse();
        set_up_tok(1'b1);
        @(negedge clk);
        set_up_tok(1'b0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, R1 to R11 not completed: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [HIT_W-1:0] fw [6];
        logic [4:0] hdr;
        logic pat [6];

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(dat_out_b | tok_out_b | dat_out_a | tok_out_a, 1'b0, "R11 outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(dat_out_b | tok_out_b | dat_out_a | tok_out_a, 1'b0, "R11 outputs after reset");

        // R1 R2 R7: table of slave readouts
        for (int v = 0; v < NV; v++) begin
            int n;
            rev_dir   = VEC[v][32];
            n         = int'(VEC[v][31:30]);
            is_master = 1'b0;
            @(negedge clk);
            for (int i = 0; i < n; i++) push_word(vword(VEC[v], i));
            token_pulse();
            chk(dn_tok(), (n == 0), "R2 token timing after receipt");
            for (int i = 0; i < n; i++) begin
                for (int b = 0; b < FRM_W; b++) begin
                    @(negedge clk);
                    chk(dn_dat(), frame_bit(vword(VEC[v], i), b), "R1 slave data bit");
                    chk(up_side_any(), 1'b0, "R7 upstream side quiet");
                end
            end
            if (n != 0) begin
                @(negedge clk);
                chk(dn_tok(), 1'b1, "R2 token after last bit");
            end
            @(negedge clk);
            chk(dn_tok(), 1'b0, "R2 token single clock");
        end

        // R3 R7: idle repeat in both directions
        for (int d = 0; d < 2; d++) begin
            rev_dir = d[0];
            @(negedge clk);
            for (int i = 0; i < 5; i++) begin
                logic bv;
                bv = (i == 1 || i == 2) ? 1'b0 : 1'b1;
                if (rev_dir) dat_in_b = bv; else dat_in_a = bv;
                @(negedge clk);
                chk(dn_dat(), bv, "R3 idle repeat delayed one clock");
                chk(rev_dir ? dat_out_b : dat_out_a, 1'b0, "R7 upstream data output held 0");
            end
            dat_in_a = 1'b0;
            dat_in_b = 1'b0;
            @(negedge clk);
        end
        rev_dir = 1'b0;

        // R9: L1 in slave mode has no effect
        pat = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
        l1_acc = 1'b1;
        for (int i = 0; i < 6; i++) begin
            dat_in_a = pat[i];
            @(negedge clk);
            l1_acc = 1'b0;
            chk(dat_out_b, pat[i], "R9 slave ignores L1 (keeps repeating)");
        end
        dat_in_a = 1'b0;
        @(negedge clk);
        chk(tok_out_b, 1'b0, "R9 slave L1 gives no token");

        // R8: run_en low freezes a readout mid-word
        push_word(10'h2D2);
        token_pulse();
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            chk(dat_out_b, frame_bit(10'h2D2, b), "R8 bits before freeze");
        end
        run_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(dat_out_b, frame_bit(10'h2D2, 2), "R8 data held while disabled");
            chk(tok_out_b, 1'b0, "R8 token held while disabled");
        end
        run_en = 1'b1;
        for (int b = 3; b < FRM_W; b++) begin
            @(negedge clk);
            chk(dat_out_b, frame_bit(10'h2D2, b), "R8 bits after resume");
        end
        @(negedge clk);
        chk(tok_out_b, 1'b1, "R8 token after resumed word");
        @(negedge clk);

        // R10: overflow drops pushes beyond DEPTH
        for (int i = 0; i < 6; i++) begin
            fw[i] = HIT_W'(10'h0A1 + 10'(i * 37));
            push_word(fw[i]);
        end
        token_pulse();
        for (int i = 0; i < DEPTH; i++) begin
            for (int b = 0; b < FRM_W; b++) begin
                @(negedge clk);
                chk(dat_out_b, frame_bit(fw[i], b), "R10 stored words only");
            end
        end
        @(negedge clk);
        chk(tok_out_b, 1'b1, "R10 token after DEPTH words");
        @(negedge clk);
        token_pulse();
        chk(tok_out_b, 1'b1, "R10 buffer empty after overflow drain");
        @(negedge clk);

        // R9: token at an idle master has no effect
        is_master = 1'b1;
        @(negedge clk);
        tok_in_a = 1'b1;
        dat_in_a = 1'b1;
        @(negedge clk);
        tok_in_a = 1'b0;
        dat_in_a = 1'b0;
        chk(tok_out_b, 1'b0, "R9 idle master ignores token");
        @(negedge clk);
        chk(dat_out_b, 1'b0, "R9 idle master keeps repeating");
        chk(tok_out_b, 1'b0, "R9 idle master no token out");

        // R4 R3 R5: master event, token returns
        l1_acc = 1'b1;
        @(negedge clk);
        l1_acc = 1'b0;
        chk(dat_out_b, 1'b0, "R4 no output bit on accept clock");
        hdr = {1'b1, 4'd0};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(dat_out_b, hdr[4 - i], "R4 header event 0");
        end
        @(negedge clk);
        chk(tok_out_b, 1'b1, "R4 master token out");
        pat = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
        for (int i = 0; i < 4; i++) begin
            dat_in_a = pat[i];
            @(negedge clk);
            chk(dat_out_b, pat[i], "R3 master repeats chain data");
        end
        tok_in_a = 1'b1;
        dat_in_a = 1'b1;
        @(negedge clk);
        tok_in_a = 1'b0;
        chk(dat_out_b, 1'b1, "R3 repeat on token return clock");
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(dat_out_b, 1'b0, "R5 trailer zero");
        end
        @(negedge clk);
        chk(dat_out_b, 1'b1, "R5 back to repeating");
        dat_in_a = 1'b0;
        @(negedge clk);

        // R4 R6: second event with own word, token never returns
        tmo_limit = 8'd5;
        push_word(10'h1C3);
        l1_acc = 1'b1;
        @(negedge clk);
        l1_acc = 1'b0;
        hdr = {1'b1, 4'd1};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(dat_out_b, hdr[4 - i], "R4 header event 1");
        end
        for (int b = 0; b < FRM_W; b++) begin
            @(negedge clk);
            chk(dat_out_b, frame_bit(10'h1C3, b), "R4 master own word");
        end
        @(negedge clk);
        chk(tok_out_b, 1'b1, "R4 token after master word");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(dat_out_b, 1'b0, "R6 waiting before timeout");
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(dat_out_b, 1'b1, "R6 error trailer");
        end
        @(negedge clk);
        chk(dat_out_b, 1'b0, "R6 idle after error trailer");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule